// File: doc/BRIEF.md
# Interleaved Dual-Port Banked Data RAM

This block is on-chip data storage shared by two processing clusters. Each cluster has its own 32-bit read/write port, addressed in bytes. Internally the storage is divided into interleaved 16-bit-wide banks. Consecutive halfwords fall in consecutive banks, so a 32-bit word sits across one even/odd bank pair. To software on either cluster, the whole array looks like one flat little-endian byte memory.

Each port's request is decoded into the set of banks it needs. When the two ports need disjoint bank sets, both are served in the same cycle. When the sets overlap, port A has fixed priority. Port B sees its ready signal drop and must hold its request until a later cycle. Reads return their data one cycle after acceptance, together with a valid strobe. Misaligned requests are flagged and dropped without touching any bank.

Top module: `banked_dual_ram`

## Requirements
- R1: The store behaves as one flat little-endian byte memory of 8*DEPTH bytes (DEPTH rows per bank, 4 banks by default). Address bits [2:1] select the bank and bits [ADDR_W-1:3] select the row inside it. Data written through either port reads back through either port.
- R2: A word access (size=1) needs addr[1:0]=00. It touches banks b and b+1, where b=addr[2:1] is even. The returned rdata[15:0] comes from bank b and rdata[31:16] from bank b+1.
- R3: A halfword access (size=0) needs addr[0]=0 and touches only bank addr[2:1]. Read data appears in rdata[15:0], and rdata[31:16] reads zero.
- R4: When both ports request and their bank sets are disjoint, both are accepted in the same cycle: a_rdy and b_rdy are both high.
- R5: When both ports present valid requests with overlapping bank sets, a_rdy stays high and b_rdy is low. In that case port B's access is not performed: a stalled write leaves memory unchanged, and a stalled read produces no b_rvalid. b_rdy is high in every other situation, and a_rdy is always high.
- R6: On a write, be[i] enables byte i of wdata (bits 8i+7:8i). A halfword write uses only be[1:0] and wdata[15:0], so be[3:2] have no effect on it.
- R7: A misaligned request raises that port's err in the same cycle. Misaligned means a word with addr[1:0]≠00, or a halfword with addr[0]=1. Such a request writes nothing, returns no read valid, and claims no bank, so it never stalls port B.
- R8: A read accepted in cycle t drives rvalid high in cycle t+1 with its data. In every other cycle rvalid is low, including after writes, idle cycles, stalls and errors.
- R9: While rst_n is low, a_rvalid and b_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_req | input | 1 | Port A request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_size | input | 1 | Port A access size: 0 halfword, 1 word |
| a_addr | input | ADDR_W | Port A byte address |
| a_be | input | 4 | Port A byte enables |
| a_wdata | input | 32 | Port A write data |
| a_rdy | output | 1 | Port A accepted (always high) |
| a_err | output | 1 | Port A misaligned request |
| a_rvalid | output | 1 | Port A read data valid |
| a_rdata | output | 32 | Port A read data |
| b_req | input | 1 | Port B request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_size | input | 1 | Port B access size: 0 halfword, 1 word |
| b_addr | input | ADDR_W | Port B byte address |
| b_be | input | 4 | Port B byte enables |
| b_wdata | input | 32 | Port B write data |
| b_rdy | output | 1 | Port B accepted this cycle |
| b_err | output | 1 | Port B misaligned request |
| b_rvalid | output | 1 | Port B read data valid |
| b_rdata | output | 32 | Port B read data |

## Verification
The array is first filled with word writes, so every later read has a known value. Directed pairs follow.

- Word/word pairs on opposite bank pairs show that both ports run in parallel.
- Halfword/halfword and word/halfword pairs that share one bank show the port-B stall. A stalled write followed by a read of the same location shows that the stalled write was dropped.
- Partial byte enables, and a halfword write carrying only upper enables, separate correct lane steering from a full-width write.
- Misaligned requests placed on a bank that port B wants show that an erroring request claims no bank.

A long random mix of sizes, directions and addresses on both ports is then compared every cycle against a flat byte-array model.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
   localparam int LANE_W = 16;
   localparam int PORT_W = 32;

   typedef enum logic {
      SZ_HALF = 1'b0,
      SZ_WORD = 1'b1
   } acc_size_e;
endpackage

// File: rtl/bdr_decode.sv
// Per-port request decoder: alignment check, bank set, row and lane steering.
module bdr_decode
   import bdr_pkg::*;
#(
   parameter  int BANKS  = 4,
   parameter  int DEPTH  = 256,
   localparam int BSEL_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(DEPTH),
   localparam int ADDR_W = ROW_W + BSEL_W + 1
) (
   input  logic                           req,
   input  logic                           we,
   input  logic                           size,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [3:0]                     be,
   input  logic [PORT_W-1:0]              wdata,
   output logic                           err,
   output logic [BANKS-1:0]               mask,
   output logic [BSEL_W-1:0]              lo_bank,
   output logic [ROW_W-1:0]               row,
   output logic [BANKS-1:0][LANE_W-1:0]   lane_wd,
   output logic [BANKS-1:0][1:0]          lane_be
);
   acc_size_e sz;
   logic      misal;
   logic      live;
   logic      word;

   assign sz = acc_size_e'(size);
   assign word = (sz == SZ_WORD);

   always_comb begin
      if (word) misal = (addr[1:0] != 2'b00);
      else      misal = addr[0];
   end

   assign err     = req & misal;
   assign live    = req & ~misal;
   assign lo_bank = addr[BSEL_W:1];
   assign row     = addr[ADDR_W-1:BSEL_W+1];

   for (genvar j = 0; j < BANKS; j++) begin : g_lane
      logic hit_lo;
      logic hit_hi;
      assign hit_lo = (lo_bank == BSEL_W'(j));
      if ((j % 2) == 1) begin : g_odd
         assign hit_hi = word & (lo_bank == BSEL_W'(j - 1));
      end else begin : g_even
         assign hit_hi = 1'b0;
      end
      assign mask[j]    = live & (hit_lo | hit_hi);
      assign lane_wd[j] = hit_hi ? wdata[31:16] : wdata[15:0];
      assign lane_be[j] = we ? (hit_hi ? be[3:2] : be[1:0]) : 2'b00;
   end
endmodule

// File: rtl/bdr_arbiter.sv
// Fixed-priority bank arbiter: port A always wins an overlap.
module bdr_arbiter #(
   parameter int BANKS = 4
) (
   input  logic [BANKS-1:0] mask_a,
   input  logic [BANKS-1:0] mask_b,
   output logic             grant_b,
   output logic [BANKS-1:0] own_b,
   output logic [BANKS-1:0] bank_en
);
   assign grant_b = ~|(mask_a & mask_b);
   assign own_b   = grant_b ? mask_b : '0;
   assign bank_en = mask_a | own_b;
endmodule

// File: rtl/bdr_bank.sv
// One 16-bit bank with byte write strobes and a registered read port.
module bdr_bank #(
   parameter  int DEPTH = 256,
   parameter  int W     = 16,
   localparam int ROW_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             en,
   input  logic             wr,
   input  logic [ROW_W-1:0] row,
   input  logic [W-1:0]     wd,
   input  logic [1:0]       be,
   output logic [W-1:0]     q
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (wr) begin
            if (be[0]) mem[row][7:0]  <= wd[7:0];
            if (be[1]) mem[row][15:8] <= wd[15:8];
         end else begin
            q <= mem[row];
         end
      end
   end
endmodule

// File: rtl/bdr_return.sv
// Read return path: remembers which bank(s) answered and assembles the word.
module bdr_return
   import bdr_pkg::*;
#(
   parameter  int BANKS  = 4,
   localparam int BSEL_W = $clog2(BANKS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fire,
   input  logic                         word,
   input  logic [BSEL_W-1:0]            lo_bank,
   input  logic [BANKS-1:0][LANE_W-1:0] bank_q,
   output logic                         rvalid,
   output logic [PORT_W-1:0]            rdata
);
   logic              v_q;
   logic              w_q;
   logic [BSEL_W-1:0] b_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         w_q <= 1'b0;
         b_q <= '0;
      end else begin
         v_q <= fire;
         if (fire) begin
            w_q <= word;
            b_q <= lo_bank;
         end
      end
   end

   assign rvalid = v_q;
   assign rdata  = w_q ? {bank_q[b_q | BSEL_W'(1)], bank_q[b_q]}
                       : {{LANE_W{1'b0}}, bank_q[b_q]};
endmodule

// File: rtl/banked_dual_ram.sv
// Two-port interleaved banked data RAM with fixed port-A priority.
module banked_dual_ram
   import bdr_pkg::*;
#(
   parameter  int BANKS  = 4,
   parameter  int DEPTH  = 256,
   localparam int BSEL_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(DEPTH),
   localparam int ADDR_W = ROW_W + BSEL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_req,
   input  logic              a_we,
   input  logic              a_size,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [3:0]        a_be,
   input  logic [31:0]       a_wdata,
   output logic              a_rdy,
   output logic              a_err,
   output logic              a_rvalid,
   output logic [31:0]       a_rdata,
   input  logic              b_req,
   input  logic              b_we,
   input  logic              b_size,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [3:0]        b_be,
   input  logic [31:0]       b_wdata,
   output logic              b_rdy,
   output logic              b_err,
   output logic              b_rvalid,
   output logic [31:0]       b_rdata
);
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("banked_dual_ram: BANKS must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("banked_dual_ram: DEPTH must be a power of two, at least 2");
   end

   logic [BANKS-1:0]             mask_a, mask_b, own_b, bank_en;
   logic [BSEL_W-1:0]            lo_a, lo_b;
   logic [ROW_W-1:0]             row_a, row_b;
   logic [BANKS-1:0][LANE_W-1:0] wd_a, wd_b, bank_q;
   logic [BANKS-1:0][1:0]        be_a, be_b;
   logic                         grant_b;
   logic                         fire_a, fire_b;

   bdr_decode #(.BANKS(BANKS), .DEPTH(DEPTH)) u_dec_a (
      .req(a_req), .we(a_we), .size(a_size), .addr(a_addr), .be(a_be),
      .wdata(a_wdata), .err(a_err), .mask(mask_a), .lo_bank(lo_a),
      .row(row_a), .lane_wd(wd_a), .lane_be(be_a)
   );

   bdr_decode #(.BANKS(BANKS), .DEPTH(DEPTH)) u_dec_b (
      .req(b_req), .we(b_we), .size(b_size), .addr(b_addr), .be(b_be),
      .wdata(b_wdata), .err(b_err), .mask(mask_b), .lo_bank(lo_b),
      .row(row_b), .lane_wd(wd_b), .lane_be(be_b)
   );

   bdr_arbiter #(.BANKS(BANKS)) u_arb (
      .mask_a(mask_a), .mask_b(mask_b), .grant_b(grant_b),
      .own_b(own_b), .bank_en(bank_en)
   );

   for (genvar j = 0; j < BANKS; j++) begin : g_bank
      logic             pick_b;
      logic             wr;
      logic [ROW_W-1:0] row;
      logic [LANE_W-1:0] wd;
      logic [1:0]       be;
      assign pick_b = own_b[j];
      assign wr     = pick_b ? b_we   : a_we;
      assign row    = pick_b ? row_b  : row_a;
      assign wd     = pick_b ? wd_b[j] : wd_a[j];
      assign be     = pick_b ? be_b[j] : be_a[j];

      bdr_bank #(.DEPTH(DEPTH), .W(LANE_W)) u_bank (
         .clk(clk), .en(bank_en[j]), .wr(wr), .row(row),
         .wd(wd), .be(be), .q(bank_q[j])
      );
   end

   assign a_rdy  = 1'b1;
   assign b_rdy  = grant_b;
   assign fire_a = a_req & ~a_err & ~a_we;
   assign fire_b = b_req & ~b_err & ~b_we & grant_b;

   bdr_return #(.BANKS(BANKS)) u_ret_a (
      .clk(clk), .rst_n(rst_n), .fire(fire_a), .word(a_size),
      .lo_bank(lo_a), .bank_q(bank_q), .rvalid(a_rvalid), .rdata(a_rdata)
   );

   bdr_return #(.BANKS(BANKS)) u_ret_b (
      .clk(clk), .rst_n(rst_n), .fire(fire_b), .word(b_size),
      .lo_bank(lo_b), .bank_q(bank_q), .rvalid(b_rvalid), .rdata(b_rdata)
   );
endmodule

// File: rtl/bdr_chk.sv
// Port-level property checker, bound to banked_dual_ram.
module bdr_chk #(
   parameter int ADDR_W = 11,
   parameter int BSEL_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_req,
   input logic              a_we,
   input logic              a_size,
   input logic [ADDR_W-1:0] a_addr,
   input logic              a_rdy,
   input logic              a_err,
   input logic              a_rvalid,
   input logic              b_req,
   input logic              b_we,
   input logic              b_size,
   input logic [ADDR_W-1:0] b_addr,
   input logic              b_rdy,
   input logic              b_err,
   input logic              b_rvalid
);
   // R8
   a_rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_rvalid |-> $past(a_req && a_rdy && !a_err && !a_we));
   // R8
   b_rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_rvalid |-> $past(b_req && b_rdy && !b_err && !b_we));
   // R8
   a_rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && a_rdy && !a_err && !a_we) |=> a_rvalid);
   // R7
   a_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && ((a_size && a_addr[1:0] != 2'b00) || (!a_size && a_addr[0]))) |-> a_err);
   // R7
   b_err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_err |=> !b_rvalid);
   // R4
   par_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && b_req && !a_size && !b_size && !a_addr[0] && !b_addr[0]
       && a_addr[BSEL_W:1] != b_addr[BSEL_W:1]) |-> b_rdy);
   // R5
   clash_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && b_req && !a_size && !b_size && !a_addr[0] && !b_addr[0]
       && a_addr[BSEL_W:1] == b_addr[BSEL_W:1]) |-> !b_rdy);
   // R5
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !b_rdy |-> (a_req && !a_err && b_req && !b_err));
endmodule

bind banked_dual_ram bdr_chk #(.ADDR_W(ADDR_W), .BSEL_W(BSEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .a_req(a_req), .a_we(a_we), .a_size(a_size), .a_addr(a_addr),
   .a_rdy(a_rdy), .a_err(a_err), .a_rvalid(a_rvalid),
   .b_req(b_req), .b_we(b_we), .b_size(b_size), .b_addr(b_addr),
   .b_rdy(b_rdy), .b_err(b_err), .b_rvalid(b_rvalid)
);

// File: tb/banked_dual_ram_test.sv
module banked_dual_ram_test;
   localparam int BANKS  = 4;
   localparam int DEPTH  = 256;
   localparam int ADDR_W = 11;
   localparam int NBYTES = 8 * DEPTH;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n;
   logic              a_req, a_we, a_size, b_req, b_we, b_size;
   logic [ADDR_W-1:0] a_addr, b_addr;
   logic [3:0]        a_be, b_be;
   logic [31:0]       a_wdata, b_wdata, a_rdata, b_rdata;
   logic              a_rdy, a_err, a_rvalid, b_rdy, b_err, b_rvalid;

   banked_dual_ram #(.BANKS(BANKS), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n),
      .a_req(a_req), .a_we(a_we), .a_size(a_size), .a_addr(a_addr),
      .a_be(a_be), .a_wdata(a_wdata), .a_rdy(a_rdy), .a_err(a_err),
      .a_rvalid(a_rvalid), .a_rdata(a_rdata),
      .b_req(b_req), .b_we(b_we), .b_size(b_size), .b_addr(b_addr),
      .b_be(b_be), .b_wdata(b_wdata), .b_rdy(b_rdy), .b_err(b_err),
      .b_rvalid(b_rvalid), .b_rdata(b_rdata)
   );

   logic [7:0] ref_mem [NBYTES];
   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic misal(input logic sz, input logic [ADDR_W-1:0] ad);
      return sz ? (ad[1:0] != 2'b00) : ad[0];
   endfunction

   function automatic logic [3:0] bset(input logic sz, input logic [ADDR_W-1:0] ad);
      return sz ? (4'b0011 << ad[2:1]) : (4'b0001 << ad[2:1]);
   endfunction

   function automatic logic [31:0] rd_ref(input logic sz, input logic [ADDR_W-1:0] ad);
      int base = int'(ad);
      if (sz) return {ref_mem[base+3], ref_mem[base+2], ref_mem[base+1], ref_mem[base]};
      return {16'h0000, ref_mem[base+1], ref_mem[base]};
   endfunction

   task automatic wr_ref(input logic sz, input logic [ADDR_W-1:0] ad,
                         input logic [3:0] be, input logic [31:0] wd);
      int base = int'(ad);
      int n = sz ? 4 : 2;
      for (int i = 0; i < n; i++)
         if (be[i]) ref_mem[base+i] = wd[8*i +: 8];
   endtask

   // One cycle: drive at negedge, check handshake, model the edge, check return.
   task automatic step(input logic ra, input logic wa, input logic sa,
                       input logic [ADDR_W-1:0] aa, input logic [3:0] ba, input logic [31:0] da,
                       input logic rb, input logic wb, input logic sb,
                       input logic [ADDR_W-1:0] ab, input logic [3:0] bb, input logic [31:0] db,
                       input string tag);
      logic ok_a, ok_b, xb, va, vb;
      logic [31:0] ea, eb;
      a_req = ra; a_we = wa; a_size = sa; a_addr = aa; a_be = ba; a_wdata = da;
      b_req = rb; b_we = wb; b_size = sb; b_addr = ab; b_be = bb; b_wdata = db;
      #1;
      ok_a = ra && !misal(sa, aa);
      ok_b = rb && !misal(sb, ab);
      xb   = !(ok_a && ok_b && ((bset(sa, aa) & bset(sb, ab)) != 4'b0000));
      chk({tag, " R5 a_rdy"}, a_rdy, 1'b1);
      chk({tag, " R4/R5 b_rdy"}, b_rdy, xb);
      chk({tag, " R7 a_err"}, a_err, ra && misal(sa, aa));
      chk({tag, " R7 b_err"}, b_err, rb && misal(sb, ab));
      @(posedge clk);
      va = ok_a && !wa;
      vb = ok_b && xb && !wb;
      ea = va ? rd_ref(sa, aa) : 32'h0;
      eb = vb ? rd_ref(sb, ab) : 32'h0;
      if (ok_a && wa) wr_ref(sa, aa, ba, da);
      if (ok_b && xb && wb) wr_ref(sb, ab, bb, db);
      @(negedge clk);
      chk({tag, " R8 a_rvalid"}, a_rvalid, va);
      chk({tag, " R8 b_rvalid"}, b_rvalid, vb);
      if (va) chk({tag, " R1 a_rdata"}, a_rdata, ea);
      if (vb) chk({tag, " R1 b_rdata"}, b_rdata, eb);
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, '0, 4'h0, 32'h0, 0, 0, 0, '0, 4'h0, 32'h0, tag);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      a_req = 0; a_we = 0; a_size = 0; a_addr = '0; a_be = '0; a_wdata = '0;
      b_req = 0; b_we = 0; b_size = 0; b_addr = '0; b_be = '0; b_wdata = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 a_rvalid in reset", a_rvalid, 1'b0);
      chk("R9 b_rvalid in reset", b_rvalid, 1'b0);
      rst_n = 1'b1;

      // R1 fill the whole array through port A, word writes
      for (int i = 0; i < NBYTES / 4; i++)
         step(1, 1, 1, ADDR_W'(4 * i), 4'hf, $urandom, 0, 0, 0, '0, 4'h0, 32'h0, "R1 fill");

      // R2 R4 word reads on opposite bank pairs run together
      step(1, 0, 1, 11'd0, 4'h0, 32'h0, 1, 0, 1, 11'd4, 4'h0, 32'h0, "R2 R4 word/word");
      step(1, 0, 1, 11'd100, 4'h0, 32'h0, 1, 0, 1, 11'd200, 4'h0, 32'h0, "R2 R4 word/word far");
      // R3 R5 halfwords on the same bank: port B stalls, then retries
      step(1, 0, 0, 11'd2, 4'h0, 32'h0, 1, 0, 0, 11'd10, 4'h0, 32'h0, "R3 R5 half clash");
      step(0, 0, 0, '0, 4'h0, 32'h0, 1, 0, 0, 11'd10, 4'h0, 32'h0, "R3 R5 retry");
      // R4 word on banks 0/1 beside a halfword on bank 3
      step(1, 0, 1, 11'd8, 4'h0, 32'h0, 1, 0, 0, 11'd6, 4'h0, 32'h0, "R4 word/half");
      // R5 word covers the halfword's bank
      step(1, 0, 1, 11'd8, 4'h0, 32'h0, 1, 0, 0, 11'd2, 4'h0, 32'h0, "R5 word/half clash");
      // R5 stalled write has no effect
      step(1, 0, 0, 11'd18, 4'h0, 32'h0, 1, 1, 0, 11'd2, 4'h3, 32'hdead_beef, "R5 stalled write");
      step(0, 0, 0, '0, 4'h0, 32'h0, 1, 0, 0, 11'd2, 4'h0, 32'h0, "R5 readback");
      // R6 partial byte enables
      step(1, 1, 1, 11'd16, 4'b0101, 32'h1122_3344, 0, 0, 0, '0, 4'h0, 32'h0, "R6 word be");
      step(0, 0, 0, '0, 4'h0, 32'h0, 1, 0, 1, 11'd16, 4'h0, 32'h0, "R6 word be readback");
      step(0, 0, 0, '0, 4'h0, 32'h0, 1, 1, 0, 11'd22, 4'b0010, 32'h0000_abcd, "R6 half be");
      step(1, 0, 1, 11'd20, 4'h0, 32'h0, 0, 0, 0, '0, 4'h0, 32'h0, "R6 half be readback");
      step(1, 1, 0, 11'd24, 4'b1100, 32'hffff_ffff, 0, 0, 0, '0, 4'h0, 32'h0, "R6 half upper be");
      step(1, 0, 1, 11'd24, 4'h0, 32'h0, 0, 0, 0, '0, 4'h0, 32'h0, "R6 upper be readback");
      // R7 misaligned requests are dropped and claim no bank
      step(1, 1, 1, 11'd2, 4'hf, 32'h5555_5555, 1, 0, 0, 11'd2, 4'h0, 32'h0, "R7 misaligned A");
      step(1, 0, 1, 11'd0, 4'h0, 32'h0, 1, 1, 0, 11'd5, 4'h3, 32'h7777_7777, "R7 misaligned B");
      step(1, 0, 1, 11'd4, 4'h0, 32'h0, 0, 0, 0, '0, 4'h0, 32'h0, "R7 readback");
      // R8 rvalid drops after the read
      idle("R8 idle");

      // R1 random mix on both ports
      for (int n = 0; n < 3000; n++) begin
         logic [ADDR_W-1:0] aa, ab;
         logic sa, sb;
         sa = 1'($urandom);
         sb = 1'($urandom);
         aa = ADDR_W'($urandom);
         ab = ADDR_W'($urandom);
         if ($urandom % 8 != 0) aa = sa ? {aa[ADDR_W-1:2], 2'b00} : {aa[ADDR_W-1:1], 1'b0};
         if ($urandom % 8 != 0) ab = sb ? {ab[ADDR_W-1:2], 2'b00} : {ab[ADDR_W-1:1], 1'b0};
         step($urandom % 5 != 0, $urandom % 5 < 2, sa, aa, 4'($urandom), $urandom,
              $urandom % 5 != 0, $urandom % 5 < 2, sb, ab, 4'($urandom), $urandom,
              "R1 random");
      end
      idle("R8 final idle");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule